// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control sequencer of a small multi-cycle processor. Each instruction starts in an entry state; the decoder presents a class vector and a few qualifying flags in that cycle, and the sequencer walks a one-hot register of sixteen numbered states until the instruction is finished. Along the way it raises per-state strobes that the datapath uses: immediate byte capture, byte load and byte store, status push and pop, and the sign fix-up after a signed multiply or divide. It also raises a fetch-next enable and a one-cycle done pulse.

Iterative work (shift, multiply, divide, square root) dwells in one state while an internal iteration counter counts the cycles down. The class and flags are captured in the entry cycle, so the decoder may change its outputs once the instruction has left the entry state. The datapath, the arithmetic and the memory port are outside this block.

Top module: `mcyc_sequencer`

## Requirements
- R1: The state output is a 16-bit one-hot vector and exactly one bit is set in every cycle after reset. Bit 0 is the entry state.
- R2: A synchronous active-high `rst` forces the state to bit 0 at the next rising edge. While `rst` is high, `done_o` and `fetch_o` are low.
- R3: Class vector bits are ALU=0, SHIFT=1, MUL=2, DIV=3, SQRT=4, LOAD=5, STORE=6, RETI=7, TRAP=8, JSR-absolute=9. The lowest set bit wins, and an all-zero vector counts as ALU. An ALU instruction with no 16-bit immediate finishes in the entry state, with `done_o` and `fetch_o` high in that cycle.
- R4: Immediate code `imm_len_i`: 00 means none, 01 means one byte, and 1x means two bytes. `imm_lo_o` is high in the entry state when the code is nonzero. A two-byte code inserts state 1, with `imm_hi_o` high, before the class path starts.
- R5: SHIFT with count n>0 stays in state 2 for n cycles and then goes to state 3. When n=0 it goes directly to state 3.
- R6: MUL stays in state 13 and DIV stays in state 11, each for the multiply or divide iteration count (default 16). When the signed flag is set, the instruction then passes through state 14 (MUL) or state 12 (DIV), with `sign_fix_o` high, before state 3. Otherwise it goes directly to state 3.
- R7: SQRT stays in state 10 for the root iteration count (default 8) and then goes to state 3. The signed flag has no effect on SQRT.
- R8: A word LOAD runs through states 4, 6 and 5, and a byte LOAD runs through state 5 only. `ld_byte_o` is high in each of these states. State 5 ends the instruction.
- R9: A word STORE runs through states 6 and 7, and a byte STORE runs through state 7 only. `st_byte_o` is high in each of these states. State 7 ends the instruction.
- R10: RETI runs through states 8, 4, 6 and 5. `ps_pop_o` is high in state 8.
- R11: TRAP runs through states 15, 9 and 7, with `ps_push_o` high in state 9. JSR-absolute runs through states 15, 6 and 7, with a byte store in states 6 and 7.
- R12: `done_o` is high only in the last state of an instruction, and the next state is state 0. `fetch_o` is high in the last cycle of an instruction, except for LOAD and STORE. For LOAD and STORE it is high in the cycle where the class path is chosen: the entry state, or state 1 when there is a two-byte immediate.
- R13: Changes to the class, width, signed, immediate or count inputs after the entry cycle have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cls_vec_i | input | 10 | Decoded instruction class, one bit per class |
| wide_i | input | 1 | 1 = word (16-bit) load/store, 0 = byte |
| signed_i | input | 1 | Signed multiply/divide |
| imm_len_i | input | 2 | Immediate length code |
| iter_n_i | input | CNT_W (5) | Shift amount |
| state_o | output | 16 | One-hot state vector |
| imm_lo_o | output | 1 | Capture low immediate byte |
| imm_hi_o | output | 1 | Capture high immediate byte |
| ld_byte_o | output | 1 | Byte load cycle |
| st_byte_o | output | 1 | Byte store cycle |
| ps_pop_o | output | 1 | Pop processor status |
| ps_push_o | output | 1 | Push processor status |
| sign_fix_o | output | 1 | Negative-operand correction cycle |
| fetch_o | output | 1 | Fetch next instruction |
| done_o | output | 1 | Instruction finishes this cycle |

## Verification
Three functions can fall in the same cycle: capturing the low immediate byte, fetching the next instruction and ending the instruction. This happens in the entry state of an ALU instruction that carries a byte immediate. For a load or store that carries a word immediate, the fetch instead coincides with the high-byte capture in state 1. The bench issues both cases back to back with other classes, and its scoreboard compares the full strobe vector in every cycle. The cycle is judged correct only when all the coincident strobes are high together and no others are.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NSTATE = 16;
  localparam int NCLS   = 10;

  // state indices
  localparam int S_ENTRY  = 0;
  localparam int S_IMMHI  = 1;
  localparam int S_STALL  = 2;
  localparam int S_FINAL  = 3;
  localparam int S_LDA    = 4;
  localparam int S_LDEND  = 5;
  localparam int S_XFER   = 6;
  localparam int S_STEND  = 7;
  localparam int S_PSPOP  = 8;
  localparam int S_PSPUSH = 9;
  localparam int S_ROOT   = 10;
  localparam int S_QUOT   = 11;
  localparam int S_QFIX   = 12;
  localparam int S_PROD   = 13;
  localparam int S_PFIX   = 14;
  localparam int S_CALL   = 15;

  typedef enum logic [3:0] {
    CL_ALU, CL_SHIFT, CL_MUL, CL_DIV, CL_SQRT,
    CL_LOAD, CL_STORE, CL_RETI, CL_TRAP, CL_JSRA
  } cls_e;

  // lowest set bit wins; empty vector is ALU
  function automatic cls_e pick_class(input logic [NCLS-1:0] v);
    cls_e c = CL_ALU;
    for (int i = NCLS - 1; i >= 0; i--)
      if (v[i]) c = cls_e'(i[3:0]);
    return c;
  endfunction

  function automatic logic is_mem(input cls_e c);
    return (c == CL_LOAD) || (c == CL_STORE);
  endfunction

  function automatic logic is_dwell(input logic [3:0] idx);
    return (idx == 4'(S_STALL)) || (idx == 4'(S_ROOT)) ||
           (idx == 4'(S_QUOT))  || (idx == 4'(S_PROD));
  endfunction
endpackage

// File: rtl/seq_entry_route.sv
module seq_entry_route
  import seq_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int MUL_ITERS  = 16,
  parameter int DIV_ITERS  = 16,
  parameter int SQRT_ITERS = 8
)(
  input  cls_e             cls_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] n_i,
  output logic [3:0]       entry_o,
  output logic             dwell_o,
  output logic [CNT_W-1:0] hval_o
);
  always_comb begin
    entry_o = 4'(S_ENTRY);
    hval_o  = '0;
    unique case (cls_i)
      CL_SHIFT: begin
        entry_o = (n_i == '0) ? 4'(S_FINAL) : 4'(S_STALL);
        hval_o  = n_i;
      end
      CL_MUL:   begin entry_o = 4'(S_PROD); hval_o = CNT_W'(MUL_ITERS);  end
      CL_DIV:   begin entry_o = 4'(S_QUOT); hval_o = CNT_W'(DIV_ITERS);  end
      CL_SQRT:  begin entry_o = 4'(S_ROOT); hval_o = CNT_W'(SQRT_ITERS); end
      CL_LOAD:  entry_o = wide_i ? 4'(S_LDA)  : 4'(S_LDEND);
      CL_STORE: entry_o = wide_i ? 4'(S_XFER) : 4'(S_STEND);
      CL_RETI:  entry_o = 4'(S_PSPOP);
      CL_TRAP,
      CL_JSRA:  entry_o = 4'(S_CALL);
      default:  entry_o = 4'(S_ENTRY);
    endcase
  end

  assign dwell_o = is_dwell(entry_o);
endmodule

// File: rtl/seq_iter_ctr.sv
module seq_iter_ctr #(
  parameter int CNT_W = 5
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dwell_i,
  output logic             last_o
);
  logic [CNT_W-1:0] h_q;

  always_ff @(posedge clk) begin
    if (rst)          h_q <= '0;
    else if (load_i)  h_q <= load_val_i;
    else if (dwell_i) h_q <= h_q - 1'b1;
  end

  assign last_o = (h_q == CNT_W'(1));

  // R5: a dwell state never sees an exhausted counter
  a_r5_dwell_live: assert property (@(posedge clk) disable iff (rst)
    dwell_i |-> h_q != '0);

  // R6: each dwell cycle consumes exactly one count
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (dwell_i && !last_o && !load_i) |=> h_q == $past(h_q) - 1'b1);
endmodule

// File: rtl/seq_strobe_dec.sv
module seq_strobe_dec
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTATE-1:0] st_i,
  input  logic [1:0]        imm_len_i,
  input  logic              wr_i,
  output logic              imm_lo_o,
  output logic              imm_hi_o,
  output logic              ld_byte_o,
  output logic              st_byte_o,
  output logic              ps_pop_o,
  output logic              ps_push_o,
  output logic              sign_fix_o
);
  assign imm_lo_o   = st_i[S_ENTRY] & (|imm_len_i);
  assign imm_hi_o   = st_i[S_IMMHI];
  assign ld_byte_o  = st_i[S_LDA] | st_i[S_LDEND] | (st_i[S_XFER] & ~wr_i);
  assign st_byte_o  = st_i[S_STEND] | (st_i[S_XFER] & wr_i);
  assign ps_pop_o   = st_i[S_PSPOP];
  assign ps_push_o  = st_i[S_PSPUSH];
  assign sign_fix_o = st_i[S_QFIX] | st_i[S_PFIX];

  // R6: sign correction only directly after a multiply or divide dwell
  a_r6_fix_after_dwell: assert property (@(posedge clk) disable iff (rst)
    sign_fix_o |-> $past(st_i[S_QUOT] | st_i[S_PROD]));

  // R11: a status push is followed by the final store byte
  a_r11_push_then_store: assert property (@(posedge clk) disable iff (rst)
    ps_push_o |=> st_byte_o);

  // R10: a status pop is followed by a load byte
  a_r10_pop_then_load: assert property (@(posedge clk) disable iff (rst)
    ps_pop_o |=> ld_byte_o);
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
  import seq_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int MUL_ITERS  = 16,
  parameter int DIV_ITERS  = 16,
  parameter int SQRT_ITERS = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCLS-1:0]   cls_vec_i,
  input  logic              wide_i,
  input  logic              signed_i,
  input  logic [1:0]        imm_len_i,
  input  logic [CNT_W-1:0]  iter_n_i,
  output logic [NSTATE-1:0] state_o,
  output logic              imm_lo_o,
  output logic              imm_hi_o,
  output logic              ld_byte_o,
  output logic              st_byte_o,
  output logic              ps_pop_o,
  output logic              ps_push_o,
  output logic              sign_fix_o,
  output logic              fetch_o,
  output logic              done_o
);
  localparam logic [NSTATE-1:0] ENTRY_OH = NSTATE'(1);

  logic [NSTATE-1:0] state_q, state_d, nxt_oh;
  logic [3:0]        nxt_idx, entry_idx;
  cls_e              cls_q, cur_cls;
  logic              wide_q, sgn_q, cur_wide, wr_q;
  logic [CNT_W-1:0]  n_q, cur_n, hval;
  logic              at_entry, imm_word, route_go, ent_dwell, h_last, in_dwell;

  // decoder fields are live in the entry cycle, latched copies afterwards
  assign at_entry = state_q[S_ENTRY];
  assign cur_cls  = at_entry ? pick_class(cls_vec_i) : cls_q;
  assign cur_wide = at_entry ? wide_i   : wide_q;
  assign cur_n    = at_entry ? iter_n_i : n_q;
  assign imm_word = imm_len_i[1];
  assign route_go = (at_entry & ~imm_word) | state_q[S_IMMHI];
  assign wr_q     = (cls_q == CL_STORE) || (cls_q == CL_JSRA);
  assign in_dwell = state_q[S_STALL] | state_q[S_ROOT] |
                    state_q[S_QUOT]  | state_q[S_PROD];

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q  <= CL_ALU;
      wide_q <= 1'b0;
      sgn_q  <= 1'b0;
      n_q    <= '0;
    end else if (at_entry) begin
      cls_q  <= pick_class(cls_vec_i);
      wide_q <= wide_i;
      sgn_q  <= signed_i;
      n_q    <= iter_n_i;
    end
  end

  seq_entry_route #(
    .CNT_W(CNT_W), .MUL_ITERS(MUL_ITERS),
    .DIV_ITERS(DIV_ITERS), .SQRT_ITERS(SQRT_ITERS)
  ) route_i (
    .cls_i(cur_cls), .wide_i(cur_wide), .n_i(cur_n),
    .entry_o(entry_idx), .dwell_o(ent_dwell), .hval_o(hval)
  );

  seq_iter_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst),
    .load_i(route_go & ent_dwell), .load_val_i(hval),
    .dwell_i(in_dwell), .last_o(h_last)
  );

  always_comb begin
    nxt_idx = 4'(S_ENTRY);
    unique case (1'b1)
      state_q[S_ENTRY]:  nxt_idx = imm_word ? 4'(S_IMMHI) : entry_idx;
      state_q[S_IMMHI]:  nxt_idx = entry_idx;
      state_q[S_STALL]:  nxt_idx = h_last ? 4'(S_FINAL) : 4'(S_STALL);
      state_q[S_ROOT]:   nxt_idx = h_last ? 4'(S_FINAL) : 4'(S_ROOT);
      state_q[S_QUOT]:   nxt_idx = !h_last ? 4'(S_QUOT) :
                                   (sgn_q ? 4'(S_QFIX) : 4'(S_FINAL));
      state_q[S_PROD]:   nxt_idx = !h_last ? 4'(S_PROD) :
                                   (sgn_q ? 4'(S_PFIX) : 4'(S_FINAL));
      state_q[S_QFIX],
      state_q[S_PFIX]:   nxt_idx = 4'(S_FINAL);
      state_q[S_LDA]:    nxt_idx = 4'(S_XFER);
      state_q[S_XFER]:   nxt_idx = wr_q ? 4'(S_STEND) : 4'(S_LDEND);
      state_q[S_PSPOP]:  nxt_idx = 4'(S_LDA);
      state_q[S_PSPUSH]: nxt_idx = 4'(S_STEND);
      state_q[S_CALL]:   nxt_idx = (cls_q == CL_TRAP) ? 4'(S_PSPUSH) : 4'(S_XFER);
      default:           nxt_idx = 4'(S_ENTRY);
    endcase
  end

  for (genvar g = 0; g < NSTATE; g++) begin : g_oh
    assign nxt_oh[g] = (nxt_idx == 4'(g));
  end

  // reset steers the next-state path
  assign state_d = rst ? ENTRY_OH : nxt_oh;

  always_ff @(posedge clk) state_q <= state_d;

  assign state_o = state_q;
  assign done_o  = ~rst & nxt_oh[S_ENTRY];
  assign fetch_o = ~rst & ((route_go & is_mem(cur_cls)) |
                           (nxt_oh[S_ENTRY] & ~is_mem(cur_cls)));

  seq_strobe_dec strobe_i (
    .clk(clk), .rst(rst), .st_i(state_q), .imm_len_i(imm_len_i), .wr_i(wr_q),
    .imm_lo_o(imm_lo_o), .imm_hi_o(imm_hi_o), .ld_byte_o(ld_byte_o),
    .st_byte_o(st_byte_o), .ps_pop_o(ps_pop_o), .ps_push_o(ps_push_o),
    .sign_fix_o(sign_fix_o)
  );

  // R1: exactly one state bit after reset
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

  // R2: reset lands in the entry state
  a_r2_reset_entry: assert property (@(posedge clk)
    rst |=> state_q == ENTRY_OH);

  // R12: a finished instruction hands over to the entry state
  a_r12_done_to_entry: assert property (@(posedge clk) disable iff (rst)
    done_o |=> state_q[S_ENTRY]);
endmodule

// File: tb/mcyc_sequencer_tb_top.sv
`timescale 1ns/1ps
module mcyc_sequencer_tb_top;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [9:0]    cls_vec = '0;
  logic          wide = 1'b0, sgn = 1'b0;
  logic [1:0]    imm = 2'b00;
  logic [CW-1:0] itn = '0;

  logic [15:0] state_o;
  logic imm_lo_o, imm_hi_o, ld_byte_o, st_byte_o, ps_pop_o, ps_push_o;
  logic sign_fix_o, fetch_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mcyc_sequencer dut_i (
    .clk(clk), .rst(rst), .cls_vec_i(cls_vec), .wide_i(wide), .signed_i(sgn),
    .imm_len_i(imm), .iter_n_i(itn), .state_o(state_o), .imm_lo_o(imm_lo_o),
    .imm_hi_o(imm_hi_o), .ld_byte_o(ld_byte_o), .st_byte_o(st_byte_o),
    .ps_pop_o(ps_pop_o), .ps_push_o(ps_push_o), .sign_fix_o(sign_fix_o),
    .fetch_o(fetch_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // expected word: {state, done, fetch, imm_lo, imm_hi, ld, st, pop, push, fix}
  function automatic logic [24:0] pack_exp(input int st, input bit dn,
                                           input bit fe, input bit lo, input bit wr);
    logic [15:0] oh;
    oh = 16'b1 << st;
    return {oh, dn, fe, lo, st == 1, (st == 4) || (st == 5) || (st == 6 && !wr),
            (st == 7) || (st == 6 && wr), st == 8, st == 9, (st == 12) || (st == 14)};
  endfunction

  // driver: computes the expected per-cycle outputs and drives one instruction
  task automatic issue(input logic [9:0] cv, input bit w, input bit s,
                       input logic [1:0] im, input int n, input string tag);
    int seq[$];
    int k;
    int entry;
    bit ls, wr;
    k = 0;
    for (int i = 9; i >= 0; i--) if (cv[i]) k = i;
    seq.push_back(0);
    if (im[1]) seq.push_back(1);
    case (k)
      1: begin for (int j = 0; j < n; j++) seq.push_back(2); seq.push_back(3); end
      2: begin for (int j = 0; j < 16; j++) seq.push_back(13);
               if (s) seq.push_back(14); seq.push_back(3); end
      3: begin for (int j = 0; j < 16; j++) seq.push_back(11);
               if (s) seq.push_back(12); seq.push_back(3); end
      4: begin for (int j = 0; j < 8; j++) seq.push_back(10); seq.push_back(3); end
      5: begin if (w) begin seq.push_back(4); seq.push_back(6); end seq.push_back(5); end
      6: begin if (w) seq.push_back(6); seq.push_back(7); end
      7: begin seq.push_back(8); seq.push_back(4); seq.push_back(6); seq.push_back(5); end
      8: begin seq.push_back(15); seq.push_back(9); seq.push_back(7); end
      9: begin seq.push_back(15); seq.push_back(6); seq.push_back(7); end
      default: ;
    endcase
    ls    = (k == 5) || (k == 6);
    wr    = (k == 6) || (k == 9);
    entry = im[1] ? 1 : 0;
    @(negedge clk);
    cls_vec = cv; wide = w; sgn = s; imm = im; itn = CW'(n);
    for (int i = 0; i < seq.size(); i++) begin
      exp_q.push_back(pack_exp(seq[i], i == seq.size() - 1,
                               ls ? (i == entry) : (i == seq.size() - 1),
                               (i == 0) && (im != 2'b00), wr));
      tag_q.push_back(tag);
    end
    // R13: scramble every input after the entry cycle
    for (int i = 1; i < seq.size(); i++) begin
      @(negedge clk);
      cls_vec = ~cv; wide = ~w; sgn = ~s; imm = 2'b11; itn = ~CW'(n);
    end
  endtask

  // monitor: pops expected items and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [24:0] e, o;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        o = {state_o, done_o, fetch_o, imm_lo_o, imm_hi_o, ld_byte_o, st_byte_o,
             ps_pop_o, ps_push_o, sign_fix_o};
        chk(o === e, t, 32'(o), 32'(e));
        chk($countones(state_o) == 1, "R1 one-hot state", 32'(state_o), 32'h1);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(state_o == 16'h0001, "R2 reset state", 32'(state_o), 32'h1);
    chk(done_o == 1'b0, "R2 done low in reset", 32'(done_o), 32'h0);
    chk(fetch_o == 1'b0, "R2 fetch low in reset", 32'(fetch_o), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    issue(10'h001, 0, 0, 2'b00, 0,  "R3 ALU single cycle");
    issue(10'h000, 0, 0, 2'b00, 0,  "R3 empty class as ALU");
    issue(10'h001, 0, 0, 2'b01, 0,  "R4 ALU byte immediate");
    issue(10'h001, 0, 0, 2'b10, 0,  "R4 ALU word immediate");
    issue(10'h002, 0, 0, 2'b00, 0,  "R5 SHIFT zero count");
    issue(10'h002, 0, 0, 2'b00, 1,  "R5 SHIFT count 1");
    issue(10'h002, 0, 0, 2'b01, 5,  "R5 SHIFT count 5");
    issue(10'h002, 0, 0, 2'b00, 31, "R5 SHIFT count 31");
    issue(10'h022, 1, 0, 2'b00, 3,  "R3 priority SHIFT over LOAD");
    issue(10'h004, 0, 0, 2'b00, 0,  "R6 MUL unsigned");
    issue(10'h004, 0, 1, 2'b00, 0,  "R6 MUL signed");
    issue(10'h008, 0, 0, 2'b00, 0,  "R6 DIV unsigned");
    issue(10'h008, 0, 1, 2'b00, 0,  "R6 DIV signed");
    issue(10'h010, 0, 1, 2'b00, 0,  "R7 SQRT signed ignored");
    issue(10'h020, 0, 0, 2'b00, 0,  "R8 LOAD byte");
    issue(10'h020, 1, 0, 2'b00, 0,  "R8 LOAD word");
    issue(10'h020, 1, 0, 2'b10, 0,  "R12 LOAD word imm fetch in state 1");
    issue(10'h040, 0, 0, 2'b00, 0,  "R9 STORE byte");
    issue(10'h040, 1, 0, 2'b01, 0,  "R9 STORE word");
    issue(10'h080, 0, 0, 2'b00, 0,  "R10 RETI");
    issue(10'h100, 0, 0, 2'b00, 0,  "R11 TRAP");
    issue(10'h200, 0, 0, 2'b00, 0,  "R11 JSR absolute");
    issue(10'h004, 0, 1, 2'b10, 0,  "R13 MUL signed word imm");

    // R2: reset in the middle of a multiply
    @(negedge clk);
    cls_vec = 10'h004; wide = 0; sgn = 0; imm = 2'b00; itn = '0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    cls_vec = '0;
    @(negedge clk);
    #1;
    chk(state_o == 16'h0001, "R2 reset mid-instruction", 32'(state_o), 32'h1);
    chk(done_o == 1'b0, "R2 done low mid reset", 32'(done_o), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    issue(10'h020, 0, 0, 2'b00, 0, "R2 recovery after reset");

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule